// File: doc/BRIEF.md
# Three-Phase Reactive Energy Accumulator

The block turns per-phase voltage and phase-shifted current samples into three signed energy counters. On every sample strobe each phase multiplies its voltage by its current and adds the signed product to a private accumulator. When that accumulator reaches a programmable positive threshold, the threshold is taken out of the accumulator and the phase's readable energy register steps up by one. When it reaches the negated threshold, the threshold is put back and the register steps down by one. Whatever is left over stays in the accumulator for the next sample.

A two-bit wiring selector sets how the middle phase (B) contributes, so that meters with three or four wires share one datapath. Each energy register wraps at its signed limits and raises a sticky flag when it does. A per-phase read-with-reset strobe clears a register when software takes its value, and no quantum is lost when one arrives in the same cycle.

Top module: `react_energy_acc`

## Requirements
- R1: While rst_ni is low, all energy outputs, all overflow flags and all internal accumulators are zero.
- R2: Without sample_valid_i, no accumulator and no energy register changes, apart from the effect of a read-with-reset strobe.
- R3: On a sample, each phase forms sum = acc + v*i. If threshold T is nonzero and sum >= T, the energy register gains +1 and acc becomes sum - T. Else if sum <= -T, the register gains -1 and acc becomes sum + T. Otherwise acc becomes sum. There is at most one quantum per phase per sample, and it is visible after that same clock edge.
- R4: A threshold of zero yields no quanta at all.
- R5: wiring_mode_i = 2'b00: phase B uses volt_b_i*curr_b_i. In every mode, phases A and C use their own voltage times their own current.
- R6: wiring_mode_i = 2'b01: phase B contributes zero power.
- R7: wiring_mode_i = 2'b10: phase B uses -(volt_a_i + volt_c_i) times curr_b_i.
- R8: wiring_mode_i = 2'b11: phase B uses -volt_a_i times curr_b_i.
- R9: An energy register at its most positive value that gains +1 becomes its most negative value, and one at its most negative value that gains -1 becomes its most positive value. Either event sets that phase's overflow flag (bit 0 = A, 1 = B, 2 = C).
- R10: An overflow flag stays set until flag_clr_i for that phase is high at a clock edge. A wrap in the same cycle as a clear leaves the flag set.
- R11: When rd_rst_i for a phase is high at a clock edge, that register takes the value of that cycle's quantum (+1, -1 or 0) in place of its old value plus the quantum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | One accumulation step per high cycle |
| wiring_mode_i | input | 2 | Phase B wiring selector |
| threshold_i | input | ACC_W | Energy quantum size, unsigned |
| volt_a_i | input | SAMPLE_W | Phase A voltage, signed |
| volt_b_i | input | SAMPLE_W | Phase B voltage, signed |
| volt_c_i | input | SAMPLE_W | Phase C voltage, signed |
| curr_a_i | input | SAMPLE_W | Phase A shifted current, signed |
| curr_b_i | input | SAMPLE_W | Phase B shifted current, signed |
| curr_c_i | input | SAMPLE_W | Phase C shifted current, signed |
| rd_rst_i | input | 3 | Per-phase read-with-reset strobe |
| flag_clr_i | input | 3 | Per-phase overflow flag clear |
| energy_a_o | output | REG_W | Phase A energy, signed |
| energy_b_o | output | REG_W | Phase B energy, signed |
| energy_c_o | output | REG_W | Phase C energy, signed |
| ovf_o | output | 3 | Sticky overflow flags |

## Verification
The bench sweeps a grid of voltages and currents through every wiring mode. A wrong phase B derivation, or one that leaked into phases A or C, shows up as energy counts that drift from the arithmetic model. Residues are kept and tracked over long runs, so a design that cleared the accumulator after each quantum, or allowed two quanta per sample, falls behind the model within a few samples. Runs driven to both signed limits, with flag clears issued on the wrapping sample, expose wrong wrap values, lost flags and a clear that beats a new wrap. Read-with-reset strobes issued while quanta are arriving catch a design that drops the quantum of that cycle.

// File: rtl/react_energy_pkg.sv
package react_energy_pkg;
  localparam int NUM_PH = 3;

  typedef enum logic [1:0] {
    WIRE_OWN     = 2'b00,
    WIRE_B_OFF   = 2'b01,
    WIRE_B_NEGAC = 2'b10,
    WIRE_B_NEGA  = 2'b11
  } wiring_e;
endpackage

// File: rtl/react_bvolt_sel.sv
module react_bvolt_sel
  import react_energy_pkg::*;
#(
  parameter int SW = 16,
  parameter int VW = SW + 2
) (
  input  wiring_e              mode_i,
  input  logic signed [SW-1:0] va_i,
  input  logic signed [SW-1:0] vb_i,
  input  logic signed [SW-1:0] vc_i,
  output logic signed [VW-1:0] vb_eff_o
);
  logic signed [VW-1:0] va_x, vb_x, vc_x;

  assign va_x = {{(VW-SW){va_i[SW-1]}}, va_i};
  assign vb_x = {{(VW-SW){vb_i[SW-1]}}, vb_i};
  assign vc_x = {{(VW-SW){vc_i[SW-1]}}, vc_i};

  always_comb begin
    unique case (mode_i)
      WIRE_OWN:     vb_eff_o = vb_x;
      WIRE_B_OFF:   vb_eff_o = '0;
      WIRE_B_NEGAC: vb_eff_o = -(va_x + vc_x);
      WIRE_B_NEGA:  vb_eff_o = -va_x;
      default:      vb_eff_o = '0;
    endcase
  end
endmodule

// File: rtl/react_phase_acc.sv
module react_phase_acc #(
  parameter int SW = 16,
  parameter int VW = SW + 2,
  parameter int AW = 48
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [VW-1:0] volt_i,
  input  logic signed [SW-1:0] curr_i,
  input  logic        [AW-1:0] thr_i,
  output logic                 q_up_o,
  output logic                 q_dn_o
);
  localparam int PW = VW + SW;

  logic signed [PW-1:0] prod;
  logic signed [AW:0]   acc_q, sum, thr_s, acc_n;
  logic                 thr_nz;

  assign prod   = volt_i * curr_i;
  assign sum    = acc_q + {{(AW+1-PW){prod[PW-1]}}, prod};
  assign thr_s  = {1'b0, thr_i};
  assign thr_nz = |thr_i;

  assign q_up_o = valid_i && thr_nz && (sum >= thr_s);
  assign q_dn_o = valid_i && thr_nz && !q_up_o && (sum <= -thr_s);

  always_comb begin
    if (q_up_o)      acc_n = sum - thr_s;
    else if (q_dn_o) acc_n = sum + thr_s;
    else             acc_n = sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (valid_i) acc_q <= acc_n;
  end
endmodule

// File: rtl/react_energy_reg.sv
module react_energy_reg #(
  parameter int RW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          q_up_i,
  input  logic          q_dn_i,
  input  logic          rd_rst_i,
  input  logic          flag_clr_i,
  output logic [RW-1:0] energy_o,
  output logic          ovf_o
);
  localparam logic [RW-1:0] MAX_V = {1'b0, {(RW-1){1'b1}}};
  localparam logic [RW-1:0] MIN_V = {1'b1, {(RW-1){1'b0}}};

  logic [RW-1:0] base, nxt;
  logic          wrap;

  // read-with-reset restarts from zero but keeps this cycle's quantum
  assign base = rd_rst_i ? '0 : energy_o;

  always_comb begin
    if (q_up_i)      nxt = base + RW'(1);
    else if (q_dn_i) nxt = base - RW'(1);
    else             nxt = base;
  end

  assign wrap = (q_up_i && base == MAX_V) || (q_dn_i && base == MIN_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      energy_o <= '0;
      ovf_o    <= 1'b0;
    end else begin
      energy_o <= nxt;
      ovf_o    <= (ovf_o && !flag_clr_i) || wrap;
    end
  end
endmodule

// File: rtl/react_energy_acc.sv
module react_energy_acc
  import react_energy_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 48,
  parameter int REG_W    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_valid_i,
  input  logic [1:0]          wiring_mode_i,
  input  logic [ACC_W-1:0]    threshold_i,
  input  logic [SAMPLE_W-1:0] volt_a_i,
  input  logic [SAMPLE_W-1:0] volt_b_i,
  input  logic [SAMPLE_W-1:0] volt_c_i,
  input  logic [SAMPLE_W-1:0] curr_a_i,
  input  logic [SAMPLE_W-1:0] curr_b_i,
  input  logic [SAMPLE_W-1:0] curr_c_i,
  input  logic [2:0]          rd_rst_i,
  input  logic [2:0]          flag_clr_i,
  output logic [REG_W-1:0]    energy_a_o,
  output logic [REG_W-1:0]    energy_b_o,
  output logic [REG_W-1:0]    energy_c_o,
  output logic [2:0]          ovf_o
);
  localparam int VW = SAMPLE_W + 2;

  logic signed [VW-1:0]       volt_x [NUM_PH];
  logic signed [SAMPLE_W-1:0] curr_x [NUM_PH];
  logic [REG_W-1:0]           energy [NUM_PH];
  logic [NUM_PH-1:0]          q_up, q_dn;

  assign volt_x[0] = {{2{volt_a_i[SAMPLE_W-1]}}, volt_a_i};
  assign volt_x[2] = {{2{volt_c_i[SAMPLE_W-1]}}, volt_c_i};
  assign curr_x[0] = curr_a_i;
  assign curr_x[1] = curr_b_i;
  assign curr_x[2] = curr_c_i;

  react_bvolt_sel #(.SW(SAMPLE_W), .VW(VW)) bsel_i (
    .mode_i   (wiring_e'(wiring_mode_i)),
    .va_i     (volt_a_i),
    .vb_i     (volt_b_i),
    .vc_i     (volt_c_i),
    .vb_eff_o (volt_x[1])
  );

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    react_phase_acc #(.SW(SAMPLE_W), .VW(VW), .AW(ACC_W)) acc_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (sample_valid_i),
      .volt_i  (volt_x[p]),
      .curr_i  (curr_x[p]),
      .thr_i   (threshold_i),
      .q_up_o  (q_up[p]),
      .q_dn_o  (q_dn[p])
    );

    react_energy_reg #(.RW(REG_W)) reg_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .q_up_i     (q_up[p]),
      .q_dn_i     (q_dn[p]),
      .rd_rst_i   (rd_rst_i[p]),
      .flag_clr_i (flag_clr_i[p]),
      .energy_o   (energy[p]),
      .ovf_o      (ovf_o[p])
    );
  end

  assign energy_a_o = energy[0];
  assign energy_b_o = energy[1];
  assign energy_c_o = energy[2];
endmodule

// File: rtl/react_energy_acc_chk.sv
module react_energy_acc_chk #(
  parameter int ACC_W = 48,
  parameter int REG_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sample_valid_i,
  input logic [ACC_W-1:0] threshold_i,
  input logic [2:0]       rd_rst_i,
  input logic [2:0]       flag_clr_i,
  input logic [REG_W-1:0] energy_a_o,
  input logic [REG_W-1:0] energy_b_o,
  input logic [REG_W-1:0] energy_c_o,
  input logic [2:0]       ovf_o
);
  localparam logic [REG_W-1:0] MAX_V = {1'b0, {(REG_W-1){1'b1}}};
  localparam logic [REG_W-1:0] MIN_V = {1'b1, {(REG_W-1){1'b0}}};
  localparam logic [REG_W-1:0] ONE_V = REG_W'(1);
  localparam logic [REG_W-1:0] NEG_V = '1;

  logic [REG_W-1:0] e [3];
  assign e[0] = energy_a_o;
  assign e[1] = energy_b_o;
  assign e[2] = energy_c_o;

  for (genvar p = 0; p < 3; p++) begin : g_chk
    a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sample_valid_i && !rd_rst_i[p]) |=> $stable(e[p]));

    a_r3_one_quantum: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_rst_i[p] |=> ((e[p] - $past(e[p])) == '0 || (e[p] - $past(e[p])) == ONE_V
                        || (e[p] - $past(e[p])) == NEG_V));

    a_r4_thr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (threshold_i == '0 && !rd_rst_i[p]) |=> $stable(e[p]));

    a_r9_wrap_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ovf_o[p]) |-> (e[p] == MAX_V || e[p] == MIN_V));

    a_r10_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_o[p] && !flag_clr_i[p]) |=> ovf_o[p]);

    a_r11_rd_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_rst_i[p] |=> (e[p] == '0 || e[p] == ONE_V || e[p] == NEG_V));
  end
endmodule

bind react_energy_acc react_energy_acc_chk #(.ACC_W(ACC_W), .REG_W(REG_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .threshold_i    (threshold_i),
  .rd_rst_i       (rd_rst_i),
  .flag_clr_i     (flag_clr_i),
  .energy_a_o     (energy_a_o),
  .energy_b_o     (energy_b_o),
  .energy_c_o     (energy_c_o),
  .ovf_o          (ovf_o)
);

// File: tb/react_energy_acc_tb.sv
module react_energy_acc_tb_top;
  localparam int SW = 8;
  localparam int AW = 24;
  localparam int RW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [AW-1:0] thr = '0;
  logic signed [SW-1:0] v [3];
  logic signed [SW-1:0] c [3];
  logic [2:0] rd = '0, clr = '0;
  logic [RW-1:0] ea, eb, ec;
  logic [2:0] ovf;

  int n_chk = 0, n_fail = 0;
  longint acc_m [3];
  longint e_m [3];
  logic [2:0] f_m;

  always #5 clk = ~clk;

  react_energy_acc #(.SAMPLE_W(SW), .ACC_W(AW), .REG_W(RW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(valid), .wiring_mode_i(mode),
    .threshold_i(thr), .volt_a_i(v[0]), .volt_b_i(v[1]), .volt_c_i(v[2]),
    .curr_a_i(c[0]), .curr_b_i(c[1]), .curr_c_i(c[2]), .rd_rst_i(rd),
    .flag_clr_i(clr), .energy_a_o(ea), .energy_b_o(eb), .energy_c_o(ec), .ovf_o(ovf)
  );

  function automatic longint veff(int p);
    if (p != 1) return longint'(v[p]);
    case (mode)
      2'b00: return longint'(v[1]);
      2'b01: return 0;
      2'b10: return -(longint'(v[0]) + longint'(v[2]));
      default: return -longint'(v[0]);
    endcase
  endfunction

  task automatic check(string tag);
    logic [RW-1:0] got [3];
    got[0] = ea; got[1] = eb; got[2] = ec;
    for (int p = 0; p < 3; p++) begin
      n_chk++;
      if (got[p] !== RW'(e_m[p])) begin
        n_fail++;
        $display("FAIL %s phase %0d energy got %0d exp %0d", tag, p, $signed(got[p]), e_m[p]);
      end
    end
    n_chk++;
    if (ovf !== f_m) begin
      n_fail++;
      $display("FAIL %s ovf got %b exp %b", tag, ovf, f_m);
    end
  endtask

  task automatic apply(logic vld, logic [2:0] r, logic [2:0] cl, string tag);
    longint s, n;
    int q;
    logic w;
    valid = vld; rd = r; clr = cl;
    for (int p = 0; p < 3; p++) begin
      q = 0;
      if (vld) begin
        s = acc_m[p] + veff(p) * longint'(c[p]);
        if (thr != 0 && s >= longint'(thr)) begin q = 1; s -= longint'(thr); end
        else if (thr != 0 && s <= -longint'(thr)) begin q = -1; s += longint'(thr); end
        acc_m[p] = s;
      end
      n = (r[p] ? 0 : e_m[p]) + q;
      w = 1'b0;
      if (n > 127) begin n -= 256; w = 1'b1; end
      if (n < -128) begin n += 256; w = 1'b1; end
      e_m[p] = n;
      f_m[p] = (f_m[p] && !cl[p]) || w;
    end
    @(negedge clk);
    valid = 1'b0; rd = '0; clr = '0;
    check(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int p = 0; p < 3; p++) begin acc_m[p] = 0; e_m[p] = 0; end
    f_m = '0;
    @(negedge clk);
    check("R1");
    rst_n = 1'b1;
  endtask

  task automatic set_grid(int i);
    v[0] = SW'(i * 37);
    v[1] = SW'(i * 53 + 11);
    v[2] = SW'(i * 29 + 101);
    for (int p = 0; p < 3; p++) c[p] = SW'(((i * 7 + p * 5) % 41) - 20);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    string tg;
    for (int p = 0; p < 3; p++) begin v[p] = '0; c[p] = '0; end

    // R1 reset state
    do_reset();

    // R4 zero threshold, R2 idle cycles
    thr = '0;
    for (int i = 0; i < 20; i++) begin
      set_grid(i);
      apply(1'b1, 3'b000, 3'b000, "R4");
      apply(1'b0, 3'b000, 3'b000, "R2");
    end

    // R3 with each wiring mode: R5 R6 R7 R8
    for (int m = 0; m < 4; m++) begin
      do_reset();
      mode = 2'(m);
      thr = AW'(3000);
      case (m)
        0: tg = "R3 R5";
        1: tg = "R3 R6";
        2: tg = "R3 R7";
        default: tg = "R3 R8";
      endcase
      for (int i = 0; i < 240; i++) begin
        set_grid(i);
        apply(1'b1, (i % 50 == 49) ? 3'b111 : 3'b000, (i % 60 == 59) ? 3'b111 : 3'b000, tg);
        if (i % 8 == 7) apply(1'b0, 3'b000, 3'b000, "R2");
      end
    end

    // R9 wrap at both limits: A climbs, B falls, C idle
    do_reset();
    mode = 2'b00;
    thr = AW'(16000);
    v[0] = 8'sd127;  c[0] = 8'sd127;
    v[1] = -8'sd128; c[1] = 8'sd127;
    v[2] = 8'sd0;    c[2] = 8'sd50;
    for (int i = 0; i < 300; i++) apply(1'b1, 3'b000, 3'b000, "R9");

    // R10 clear every sample: set on wrap must win
    for (int i = 0; i < 300; i++) apply(1'b1, 3'b000, 3'b111, "R10");
    apply(1'b0, 3'b000, 3'b111, "R10");

    // R11 read-with-reset while quanta arrive
    do_reset();
    thr = AW'(100);
    v[0] = 8'sd10;  c[0] = 8'sd15;
    v[1] = 8'sd0;   c[1] = 8'sd3;
    v[2] = -8'sd9;  c[2] = 8'sd13;
    for (int i = 0; i < 60; i++)
      apply(1'b1, (i % 9 == 8) ? 3'b111 : 3'b000, 3'b000, "R11");
    apply(1'b0, 3'b111, 3'b000, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule